// File: doc/BRIEF.md
# Masked Rectangle Copy and Fill Engine

The engine moves and paints rectangles inside an external 16-bit pixel memory that is organised as a power-of-two grid of columns and rows. A copy reads each source pixel and the destination pixel it replaces, then decides whether the write may happen. A destination pixel that carries a protected bit, selected by a mask value, is left alone. Every pixel that is written has a chosen mask bit forced on. When the source and destination share rows, the engine walks each row right-to-left whenever a left-to-right walk could overwrite source pixels before they are read. The wrap rule that picks this order is the one in R4.

A fill paints a rectangle with a single colour. The colour arrives as a 32-bit value with 8 bits per channel and is packed to 16 bits first. In interlaced mode the fill leaves untouched the rows that belong to the field now on screen. Every coordinate wraps at the grid edges. A command is accepted with a one-cycle valid strobe while the engine is idle. `done_o` marks completion.

Top module: `rect_blit_engine`

## Requirements
- R1: While reset is asserted and after it is released, `busy_o`, `done_o`, `mem_rd_o` and `mem_wr_o` are 0 until a command is accepted.
- R2: The pixel at column x and row y has address y*MEM_W + x, with x taken modulo MEM_W and y modulo MEM_H. This holds for both source and destination coordinates, for copy and for fill.
- R3: A copy writes a destination pixel only when (old destination & mask_and) == 0. The value written is source | mask_or. mask_and and mask_or are captured when the command is accepted.
- R4: A copy visits columns from width-1 down to 0 when either of two conditions holds; otherwise it visits them from 0 upward. The first condition is (src_x mod MEM_W) < (dst_x mod MEM_W). The second is ((src_x+width-1) mod MEM_W) < ((dst_x+width-1) mod MEM_W). Rows always go from 0 upward.
- R5: Each copied pixel takes two cycles. In the first, `mem_rd_o` is high and presents the source and destination addresses together. In the second, the read data is used and the conditional write happens. Reads and writes never occur in the same cycle.
- R6: A fill writes {c[31], c[23:19], c[15:11], c[7:3]} for cmd_color_i = c. Blue sits in bits 14:10, green in 9:5, red in 4:0, and the alpha bit in bit 15.
- R7: With ilace_en_i=1 at acceptance, a fill skips every destination row whose (wrapped) row bit 0 equals ilace_field_i. Each skipped row costs one cycle. With ilace_en_i=0 every row is written.
- R8: A fill ignores mask_and and mask_or and writes the packed colour unconditionally.
- R9: `done_o` is high for exactly one cycle, in the cycle after the last pixel cycle. `busy_o` is high from the cycle after acceptance through the `done_o` cycle and low in the cycle after it.
- R10: A command presented while `busy_o` is high is ignored and does not change the running operation.
- R11: A command with width 0 or height 0 performs no memory access, and `done_o` is high in the cycle after acceptance.
- R12: A fill writes one pixel per cycle, walking columns from 0 upward within a row and rows from 0 upward. A fill of N written pixels with no skipped rows gives `done_o` N+1 cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe, taken when idle |
| cmd_op_i | input | 1 | 0 = copy, 1 = fill |
| cmd_src_x_i | input | CW | Source column (copy) |
| cmd_src_y_i | input | CW | Source row (copy) |
| cmd_dst_x_i | input | CW | Destination column |
| cmd_dst_y_i | input | CW | Destination row |
| cmd_width_i | input | CW | Rectangle width in pixels |
| cmd_height_i | input | CW | Rectangle height in rows |
| cmd_color_i | input | 32 | Fill colour, 8 bits per channel |
| mask_and_i | input | 16 | Protection test mask for copy |
| mask_or_i | input | 16 | Bits forced on in copied pixels |
| ilace_en_i | input | 1 | Interlaced fill enable |
| ilace_field_i | input | 1 | Field currently displayed |
| mem_rd_o | output | 1 | Read strobe for both read addresses |
| mem_rd_src_addr_o | output | AW | Source pixel read address |
| mem_rd_dst_addr_o | output | AW | Destination pixel read address |
| mem_src_data_i | input | 16 | Source pixel, one cycle after the read |
| mem_dst_data_i | input | 16 | Destination pixel, one cycle after the read |
| mem_wr_o | output | 1 | Write strobe |
| mem_wr_addr_o | output | AW | Write address |
| mem_wr_data_o | output | 16 | Write data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Completion timing is fixed by the requirements, measured in cycles after the accepting edge:
- a zero-size command completes after 1 cycle;
- a copy of N pixels completes after 2N+1 cycles;
- a fill completes after (written pixels + skipped rows + 1) cycles.

The bench drives each command at a falling edge and lets the next rising edge accept it. It then counts falling edges until `done_o` is seen and compares that count exactly with the formula. It also checks that `done_o` and `busy_o` are low one cycle later. Memory-image and write-order results are compared against a bench model only after `done_o`, once all writes have landed in the bench's registered memory model.

// File: rtl/rcopy_pkg.sv
package rcopy_pkg;
  typedef enum logic {
    RC_COPY = 1'b0,
    RC_FILL = 1'b1
  } rc_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CP_RD,
    ST_CP_WR,
    ST_FILL,
    ST_FIN
  } rc_state_e;
endpackage

// File: rtl/rc_rect_walker.sv
module rc_rect_walker #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] w_i,
  input  logic [CW-1:0] h_i,
  input  logic          rev_i,
  input  logic          step_i,
  input  logic          skip_row_i,
  output logic [CW-1:0] col_o,
  output logic [CW-1:0] row_o,
  output logic          row_last_o,
  output logic          last_o
);
  logic [CW-1:0] col_q, row_q, w_q, h_q;
  logic          rev_q;
  logic [CW-1:0] col_first;
  logic          col_end;

  assign col_first  = rev_q ? (w_q - CW'(1)) : '0;
  assign col_end    = rev_q ? (col_q == '0) : (col_q == w_q - CW'(1));
  assign row_last_o = (row_q == h_q - CW'(1));
  assign last_o     = row_last_o && col_end;
  assign col_o      = col_q;
  assign row_o      = row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
      row_q <= '0;
      w_q   <= '0;
      h_q   <= '0;
      rev_q <= 1'b0;
    end else if (load_i) begin
      w_q   <= w_i;
      h_q   <= h_i;
      rev_q <= rev_i;
      col_q <= rev_i ? (w_i - CW'(1)) : '0;
      row_q <= '0;
    end else if (skip_row_i || (step_i && col_end)) begin
      col_q <= col_first;
      row_q <= row_q + CW'(1);
    end else if (step_i) begin
      col_q <= rev_q ? (col_q - CW'(1)) : (col_q + CW'(1));
    end
  end

  // R4: column index stays inside the rectangle while pixels are processed
  p_col_in_rect_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> (col_q < w_q));
  // R4: reverse walk moves the column down by one within a row
  p_rev_walk_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !col_end && rev_q && !load_i) |=> (col_q == $past(col_q) - CW'(1)));
endmodule

// File: rtl/rc_mask_merge.sv
module rc_mask_merge (
  input  logic [15:0] src_px_i,
  input  logic [15:0] dst_px_i,
  input  logic [15:0] mask_and_i,
  input  logic [15:0] mask_or_i,
  output logic        wr_ok_o,
  output logic [15:0] px_o
);
  assign wr_ok_o = ((dst_px_i & mask_and_i) == 16'h0000);
  assign px_o    = src_px_i | mask_or_i;
endmodule

// File: rtl/rc_color_pack.sv
module rc_color_pack (
  input  logic [31:0] rgba_i,
  output logic [15:0] px_o
);
  // alpha msb, then 5 msbs of blue, green, red
  assign px_o = {rgba_i[31], rgba_i[23:19], rgba_i[15:11], rgba_i[7:3]};
endmodule

// File: rtl/rect_blit_engine.sv
module rect_blit_engine
  import rcopy_pkg::*;
#(
  parameter int MEM_W = 1024,
  parameter int MEM_H = 512,
  parameter int CW    = 16
) (
  input  logic                                      clk_i,
  input  logic                                      rst_ni,
  input  logic                                      cmd_valid_i,
  input  logic                                      cmd_op_i,
  input  logic [CW-1:0]                             cmd_src_x_i,
  input  logic [CW-1:0]                             cmd_src_y_i,
  input  logic [CW-1:0]                             cmd_dst_x_i,
  input  logic [CW-1:0]                             cmd_dst_y_i,
  input  logic [CW-1:0]                             cmd_width_i,
  input  logic [CW-1:0]                             cmd_height_i,
  input  logic [31:0]                               cmd_color_i,
  input  logic [15:0]                               mask_and_i,
  input  logic [15:0]                               mask_or_i,
  input  logic                                      ilace_en_i,
  input  logic                                      ilace_field_i,
  output logic                                      mem_rd_o,
  output logic [$clog2(MEM_W)+$clog2(MEM_H)-1:0]    mem_rd_src_addr_o,
  output logic [$clog2(MEM_W)+$clog2(MEM_H)-1:0]    mem_rd_dst_addr_o,
  input  logic [15:0]                               mem_src_data_i,
  input  logic [15:0]                               mem_dst_data_i,
  output logic                                      mem_wr_o,
  output logic [$clog2(MEM_W)+$clog2(MEM_H)-1:0]    mem_wr_addr_o,
  output logic [15:0]                               mem_wr_data_o,
  output logic                                      busy_o,
  output logic                                      done_o
);
  localparam int XW = $clog2(MEM_W);
  localparam int YW = $clog2(MEM_H);
  localparam int AW = XW + YW;

  rc_state_e     state_q, state_d;
  rc_op_e        op_q;
  logic [XW-1:0] sx_q, dx_q;
  logic [YW-1:0] sy_q, dy_q;
  logic [15:0]   mand_q, mor_q, fill_px_q, fill_px_c;
  logic          ilace_q, field_q;

  logic          accept, zero_sz, rev_c;
  logic [XW-1:0] sxr, dxr, wl, s_end, d_end;
  logic [CW-1:0] col, row;
  logic          last, row_last, step, skip_row, row_skip;
  logic [XW-1:0] cur_sx, cur_dx;
  logic [YW-1:0] cur_sy, cur_dy;
  logic          wr_ok;
  logic [15:0]   merged_px;

  assign accept  = cmd_valid_i && (state_q == ST_IDLE);
  assign zero_sz = (cmd_width_i == '0) || (cmd_height_i == '0);

  // overlap-safe column order, decided on wrapped start and end columns
  assign sxr   = cmd_src_x_i[XW-1:0];
  assign dxr   = cmd_dst_x_i[XW-1:0];
  assign wl    = cmd_width_i[XW-1:0];
  assign s_end = sxr + wl - XW'(1);
  assign d_end = dxr + wl - XW'(1);
  assign rev_c = (cmd_op_i == RC_COPY) && ((sxr < dxr) || (s_end < d_end));

  rc_color_pack u_pack (
    .rgba_i (cmd_color_i),
    .px_o   (fill_px_c)
  );

  rc_rect_walker #(.CW(CW)) u_walk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .w_i        (cmd_width_i),
    .h_i        (cmd_height_i),
    .rev_i      (rev_c),
    .step_i     (step),
    .skip_row_i (skip_row),
    .col_o      (col),
    .row_o      (row),
    .row_last_o (row_last),
    .last_o     (last)
  );

  assign cur_sx = sx_q + col[XW-1:0];
  assign cur_dx = dx_q + col[XW-1:0];
  assign cur_sy = sy_q + row[YW-1:0];
  assign cur_dy = dy_q + row[YW-1:0];

  rc_mask_merge u_merge (
    .src_px_i   (mem_src_data_i),
    .dst_px_i   (mem_dst_data_i),
    .mask_and_i (mand_q),
    .mask_or_i  (mor_q),
    .wr_ok_o    (wr_ok),
    .px_o       (merged_px)
  );

  assign row_skip = ilace_q && (cur_dy[0] == field_q);
  assign step     = (state_q == ST_CP_WR) || ((state_q == ST_FILL) && !row_skip);
  assign skip_row = (state_q == ST_FILL) && row_skip;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = zero_sz ? ST_FIN :
                  ((cmd_op_i == RC_FILL) ? ST_FILL : ST_CP_RD);
      ST_CP_RD: state_d = ST_CP_WR;
      ST_CP_WR: state_d = last ? ST_FIN : ST_CP_RD;
      ST_FILL:  if (row_skip ? row_last : last) state_d = ST_FIN;
      ST_FIN:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      op_q      <= RC_COPY;
      sx_q      <= '0;
      sy_q      <= '0;
      dx_q      <= '0;
      dy_q      <= '0;
      mand_q    <= '0;
      mor_q     <= '0;
      fill_px_q <= '0;
      ilace_q   <= 1'b0;
      field_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        op_q      <= rc_op_e'(cmd_op_i);
        sx_q      <= sxr;
        dx_q      <= dxr;
        sy_q      <= cmd_src_y_i[YW-1:0];
        dy_q      <= cmd_dst_y_i[YW-1:0];
        mand_q    <= mask_and_i;
        mor_q     <= mask_or_i;
        fill_px_q <= fill_px_c;
        ilace_q   <= ilace_en_i;
        field_q   <= ilace_field_i;
      end
    end
  end

  assign mem_rd_o          = (state_q == ST_CP_RD);
  assign mem_rd_src_addr_o = {cur_sy, cur_sx};
  assign mem_rd_dst_addr_o = {cur_dy, cur_dx};
  assign mem_wr_o          = ((state_q == ST_CP_WR) && wr_ok) ||
                             ((state_q == ST_FILL) && !row_skip);
  assign mem_wr_addr_o     = {cur_dy, cur_dx};
  assign mem_wr_data_o     = (state_q == ST_FILL) ? fill_px_q : merged_px;
  assign busy_o            = (state_q != ST_IDLE);
  assign done_o            = (state_q == ST_FIN);

  // R5: never read and write in one cycle
  p_rd_wr_exclusive_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));
  // R5: a copy write always follows its read cycle
  p_copy_wr_after_rd_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_o && op_q == RC_COPY) |-> $past(mem_rd_o));
  // R3: copied pixels carry the forced mask bits
  p_copy_or_bits_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_o && op_q == RC_COPY) |-> ((mem_wr_data_o & mor_q) == mor_q));
  // R7: no fill write lands on a row of the displayed field
  p_fill_field_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_o && op_q == RC_FILL && ilace_q) |-> (mem_wr_addr_o[XW] != field_q));
  // R9: done is a single-cycle pulse and the engine is idle after it
  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));
  // R10: command fields are frozen while busy
  p_busy_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(op_q) && $stable(dx_q) && $stable(dy_q) && $stable(fill_px_q)));
  // R11: zero-size command completes with no memory access
  p_zero_done_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && zero_sz) |=> (done_o && !mem_rd_o && !mem_wr_o));
endmodule

// File: tb/rect_blit_engine_tb.sv
module rect_blit_engine_tb;
  localparam int MW = 64;
  localparam int MH = 32;
  localparam int CW = 16;
  localparam int AW = 11;
  localparam int MSZ = MW * MH;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          cmd_valid = 1'b0, cmd_op = 1'b0;
  logic [CW-1:0] sx = '0, sy = '0, dx = '0, dy = '0, cw = '0, ch = '0;
  logic [31:0]   color = '0;
  logic [15:0]   mand = '0, mor = '0;
  logic          ien = 1'b0, ifld = 1'b0;
  logic          mem_rd, mem_wr, busy, done;
  logic [AW-1:0] rsa, rda, wa;
  logic [15:0]   src_q, dst_q, wd;

  rect_blit_engine #(.MEM_W(MW), .MEM_H(MH), .CW(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_src_x_i(sx), .cmd_src_y_i(sy), .cmd_dst_x_i(dx), .cmd_dst_y_i(dy),
    .cmd_width_i(cw), .cmd_height_i(ch), .cmd_color_i(color),
    .mask_and_i(mand), .mask_or_i(mor), .ilace_en_i(ien), .ilace_field_i(ifld),
    .mem_rd_o(mem_rd), .mem_rd_src_addr_o(rsa), .mem_rd_dst_addr_o(rda),
    .mem_src_data_i(src_q), .mem_dst_data_i(dst_q), .mem_wr_o(mem_wr),
    .mem_wr_addr_o(wa), .mem_wr_data_o(wd), .busy_o(busy), .done_o(done));

  logic [15:0]   mem [MSZ];
  logic [15:0]   ref_m [MSZ];
  logic [AW-1:0] wlog [256];
  int            wcnt = 0;
  int            nchk = 0, nerr = 0;

  always @(posedge clk) begin
    if (mem_rd) begin
      src_q <= mem[rsa];
      dst_q <= mem[rda];
    end
    if (mem_wr) begin
      mem[wa] <= wd;
      wlog[wcnt % 256] <= wa;
      wcnt <= wcnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int adr(input int x, input int y);
    return ((y % MH) * MW) + (x % MW);
  endfunction

  function automatic logic [15:0] pack(input logic [31:0] c);
    return {c[31], c[23:19], c[15:11], c[7:3]};
  endfunction

  task automatic init_mem();
    for (int i = 0; i < MSZ; i++) begin
      mem[i]   = 16'((i * 40503) + 4660);
      ref_m[i] = mem[i];
    end
  endtask

  task automatic ref_copy(input int x0, input int y0, input int x1, input int y1,
                          input int w, input int h, input logic [15:0] a,
                          input logic [15:0] o);
    bit rv;
    rv = ((x0 % MW) < (x1 % MW)) || (((x0 + w - 1) % MW) < ((x1 + w - 1) % MW));
    for (int r = 0; r < h; r++)
      for (int k = 0; k < w; k++) begin
        int c;
        c = rv ? (w - 1 - k) : k;
        if ((ref_m[adr(x1 + c, y1 + r)] & a) == 16'h0)
          ref_m[adr(x1 + c, y1 + r)] = ref_m[adr(x0 + c, y0 + r)] | o;
      end
  endtask

  task automatic ref_fill(input int x1, input int y1, input int w, input int h,
                          input logic [31:0] c, input bit ie, input bit f);
    for (int r = 0; r < h; r++) begin
      int y;
      y = (y1 + r) % MH;
      if (!(ie && ((y % 2) == int'(f))))
        for (int k = 0; k < w; k++) ref_m[adr(x1 + k, y)] = pack(c);
    end
  endtask

  task automatic drive(input bit op, input int x0, input int y0, input int x1,
                       input int y1, input int w, input int h, input logic [31:0] c,
                       input logic [15:0] a, input logic [15:0] o, input bit ie,
                       input bit f);
    cmd_op = op; sx = CW'(x0); sy = CW'(y0); dx = CW'(x1); dy = CW'(y1);
    cw = CW'(w); ch = CW'(h); color = c; mand = a; mor = o; ien = ie; ifld = f;
  endtask

  // accept at the next rising edge, return edges counted until done is seen
  task automatic run(output int cyc);
    @(negedge clk);
    cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    cyc = 1;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic check_after_done(input string req);
    @(negedge clk);
    chk(!done && !busy, req, "done/busy one cycle after done", {done, busy}, 0);
  endtask

  task automatic cmp_mem(input string req);
    int bad, first;
    bad = 0; first = 0;
    for (int i = 0; i < MSZ; i++)
      if (mem[i] !== ref_m[i]) begin
        if (bad == 0) first = i;
        bad++;
      end
    chk(bad == 0, req, "memory mismatches", bad, 0);
    if (bad != 0) $display("  first at %0d: %0h vs %0h", first, mem[first], ref_m[first]);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!busy && !done && !mem_rd && !mem_wr, "R1", "outputs in reset",
        {busy, done, mem_rd, mem_wr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(!busy && !done && !mem_rd && !mem_wr, "R1", "outputs after reset",
        {busy, done, mem_rd, mem_wr}, 0);
  endtask

  task automatic t_copy_fwd();
    int cyc, b;
    init_mem();
    b = wcnt;
    drive(0, 10, 2, 4, 2, 5, 3, 0, 16'h0, 16'h0, 0, 0);
    ref_copy(10, 2, 4, 2, 5, 3, 16'h0, 16'h0);
    run(cyc);
    chk(cyc == 31, "R5", "copy cycles 2N+1", cyc, 31);
    chk(int'(wlog[b % 256]) == adr(4, 2), "R4", "forward first write", int'(wlog[b % 256]), adr(4, 2));
    check_after_done("R9");
    cmp_mem("R2");
  endtask

  task automatic t_copy_rev();
    int cyc, b;
    init_mem();
    b = wcnt;
    drive(0, 2, 7, 5, 7, 6, 2, 0, 16'h0, 16'h0, 0, 0);
    ref_copy(2, 7, 5, 7, 6, 2, 16'h0, 16'h0);
    run(cyc);
    chk(int'(wlog[b % 256]) == adr(10, 7), "R4", "reverse first write", int'(wlog[b % 256]), adr(10, 7));
    cmp_mem("R4");
  endtask

  task automatic t_copy_end_rev();
    int cyc, b;
    init_mem();
    b = wcnt;
    drive(0, 62, 4, 10, 9, 4, 1, 0, 16'h0, 16'h0, 0, 0);
    ref_copy(62, 4, 10, 9, 4, 1, 16'h0, 16'h0);
    run(cyc);
    chk(int'(wlog[b % 256]) == adr(13, 9), "R4", "end-compare first write", int'(wlog[b % 256]), adr(13, 9));
    chk(int'(wlog[(b + 1) % 256]) == adr(12, 9), "R4", "end-compare second write", int'(wlog[(b + 1) % 256]), adr(12, 9));
    cmp_mem("R4");
  endtask

  task automatic t_copy_wrap();
    int cyc, b;
    init_mem();
    b = wcnt;
    drive(0, 124, 62, 58, 29, 10, 5, 0, 16'h0, 16'h0, 0, 0);
    ref_copy(124, 62, 58, 29, 10, 5, 16'h0, 16'h0);
    run(cyc);
    chk(cyc == 101, "R5", "wrapped copy cycles", cyc, 101);
    chk(int'(wlog[b % 256]) == adr(58, 29), "R2", "wrapped first write", int'(wlog[b % 256]), adr(58, 29));
    cmp_mem("R2");
  endtask

  task automatic t_copy_mask();
    int cyc, b, nfree;
    init_mem();
    nfree = 0;
    for (int r = 0; r < 2; r++)
      for (int k = 0; k < 16; k++)
        if (!ref_m[adr(k, 20 + r)][15]) nfree++;
    b = wcnt;
    drive(0, 0, 10, 0, 20, 16, 2, 0, 16'h8000, 16'h8000, 0, 0);
    ref_copy(0, 10, 0, 20, 16, 2, 16'h8000, 16'h8000);
    run(cyc);
    chk(wcnt - b == nfree, "R3", "writes to unprotected pixels", wcnt - b, nfree);
    chk(cyc == 65, "R5", "masked copy cycles", cyc, 65);
    cmp_mem("R3");
  endtask

  task automatic t_fill_basic();
    int cyc, b;
    init_mem();
    b = wcnt;
    drive(1, 0, 0, 5, 12, 7, 3, 32'h12345678, 16'h0, 16'h0, 0, 0);
    ref_fill(5, 12, 7, 3, 32'h12345678, 0, 0);
    run(cyc);
    chk(cyc == 22, "R12", "fill cycles N+1", cyc, 22);
    chk(int'(wlog[(b + 1) % 256]) == adr(6, 12), "R12", "fill second write", int'(wlog[(b + 1) % 256]), adr(6, 12));
    chk(mem[adr(5, 12)] == 16'h194F, "R6", "packed colour", mem[adr(5, 12)], 16'h194F);
    check_after_done("R9");
    cmp_mem("R6");
  endtask

  task automatic t_fill_mask();
    int cyc;
    init_mem();
    drive(1, 0, 0, 20, 1, 12, 4, 32'h7F00FF00, 16'h8000, 16'h8000, 0, 0);
    ref_fill(20, 1, 12, 4, 32'h7F00FF00, 0, 0);
    run(cyc);
    chk(mem[adr(31, 4)] == 16'h03E0, "R8", "fill ignores masks", mem[adr(31, 4)], 16'h03E0);
    cmp_mem("R8");
  endtask

  task automatic t_fill_ilace(input bit f);
    int cyc;
    init_mem();
    drive(1, 0, 0, 62, 3, 5, 4, 32'h80000000, 16'h0, 16'h0, 1, f);
    ref_fill(62, 3, 5, 4, 32'h80000000, 1, f);
    run(cyc);
    chk(cyc == 13, "R7", "interlaced fill cycles", cyc, 13);
    cmp_mem("R7");
  endtask

  task automatic t_zero();
    int cyc, b;
    init_mem();
    b = wcnt;
    drive(0, 1, 1, 2, 2, 0, 3, 0, 16'h0, 16'h0, 0, 0);
    run(cyc);
    chk(cyc == 1, "R11", "zero-width copy done", cyc, 1);
    drive(1, 0, 0, 2, 2, 4, 0, 32'hFFFFFFFF, 16'h0, 16'h0, 0, 0);
    run(cyc);
    chk(cyc == 1, "R11", "zero-height fill done", cyc, 1);
    chk(wcnt == b, "R11", "no writes", wcnt - b, 0);
    cmp_mem("R11");
  endtask

  task automatic t_busy_ignore();
    int cyc;
    init_mem();
    drive(0, 0, 5, 30, 6, 4, 2, 0, 16'h0, 16'h0, 0, 0);
    ref_copy(0, 5, 30, 6, 4, 2, 16'h0, 16'h0);
    @(negedge clk);
    cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    drive(1, 0, 0, 0, 0, 8, 8, 32'hFFFFFFFF, 16'h0, 16'h0, 0, 0);
    cyc = 1;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    cmd_valid = 1'b0;
    chk(cyc == 17, "R10", "copy timing with command while busy", cyc, 17);
    @(negedge clk);
    @(negedge clk);
    chk(!busy, "R10", "no command taken while busy", busy, 0);
    cmp_mem("R10");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    t_reset();
    t_copy_fwd();
    t_copy_rev();
    t_copy_end_rev();
    t_copy_wrap();
    t_copy_mask();
    t_fill_basic();
    t_fill_mask();
    t_fill_ilace(1'b0);
    t_fill_ilace(1'b1);
    t_zero();
    t_busy_ignore();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule